// File: doc/BRIEF.md
# Power-Loss Shutdown Sequencer

This block sits between a board-level power-fail comparator and the functional logic of a memory module. It waits for a qualified power-fail indication, then runs the module down in a fixed order. First it throttles the load. It then writes a short, timestamped header record as a single burst. Next it requests a data flush, bounded by a watchdog. It writes one closing record, and finally it raises a power-off request. All of this must fit inside the hold-up window of the storage capacitors.

The sequence starts only once, and it latches. Power-good or detect chatter during hold-up cannot restart it, and only the power-on reset clears it. If the storage voltage drops below its minimum at any point after the start, the remaining steps are abandoned and power-off is raised at once. The header carries a boot epoch and a free-running timestamp, so records can be stitched together across resets. It also carries a binned detect latency, which is the number of clock edges from the first power-fail sample to qualification.

Top module: `plf_shutdown_seq`

## Requirements
- R1: While rst_ni is low, throttle_o, safe_entered_o, flush_req_o, log_we_o and poweroff_o are 0, and lat_bin_o and last_commit_o are 0.
- R2: The sequence starts on the clock edge that samples pfail_i high for the QUAL_CYC-th (2) consecutive time. A single high sample is not enough. From the next cycle, throttle_o and safe_entered_o are 1 until reset.
- R3: From the first throttled cycle, log_we_o is high for exactly 5 consecutive cycles carrying the header. The header is {8'hA1, lat_bin, epoch_i, tstamp_i, snap_i}, zero-padded at the low end to 80 bits and sent most significant 16-bit word first. epoch_i, tstamp_i and snap_i are taken at the start edge.
- R4: flush_req_o rises in the cycle after the last header word and never earlier. At that point last_commit_o reads 1 (header committed).
- R5: When flush_done_i is sampled high during flush, the next cycle drops flush_req_o and writes one closing word {8'hC0, tstamp_i[7:0]}. The cycle after that, poweroff_o is 1 and last_commit_o reads 2 (closing record committed).
- R6: If flush_done_i is not seen within FLUSH_TMO (16) flush cycles, flush_req_o stays high for exactly 16 cycles. The closing word is then {8'hE5, tstamp_i[7:0]}, followed by power-off as in R5. A flush_done_i sampled in the 16th cycle still counts as done.
- R7: Once started, vstore_ok_i sampled low forces poweroff_o high in the next cycle. No further log write or flush request follows, and last_commit_o keeps its value.
- R8: After the start, pfail_i has no effect. The header is not restarted, and after power-off, poweroff_o stays high with log_we_o and flush_req_o low until reset.
- R9: The detect latency L counts clock edges from the first edge that samples pfail_i high after reset, through the start edge inclusive, saturating at 255. lat_bin_o = min(L >> 2, 15), fixed from the first throttled cycle. The same value is carried in the header.
- R10: Before the start, vstore_ok_i low has no effect: throttle_o, log_we_o and poweroff_o stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| pfail_i | input | 1 | Power-fail detect from the comparator |
| vstore_ok_i | input | 1 | Storage voltage above minimum safe level |
| flush_done_i | input | 1 | Flush handshake completion |
| tstamp_i | input | TS_W | Free-running monotonic timestamp |
| epoch_i | input | EP_W | Boot epoch counter |
| snap_i | input | SNAP_W | Rail/thermal snapshot word |
| throttle_o | output | 1 | Safe-mode load throttle |
| safe_entered_o | output | 1 | Sticky flag: safe mode entered |
| flush_req_o | output | 1 | Flush request |
| log_we_o | output | 1 | Log write strobe |
| log_data_o | output | LOG_W | Log write data |
| poweroff_o | output | 1 | Clean power-off request |
| lat_bin_o | output | BIN_W | Binned detect latency |
| last_commit_o | output | 2 | Last committed record: 0 none, 1 header, 2 closing |

## Verification
The assertions assume that vstore_ok_i is treated as meaningful only once throttling has begun. They also assume flush_done_i is a level sampled on the clock, with no particular relation to flush_req_o. The stimulus drives every input half a cycle away from the active edge. It raises flush_done_i only while a flush is requested, except in the chatter cases, where pfail_i toggles freely after the start to show it is ignored. Latency bins come from pulse-then-gap patterns on pfail_i whose edge counts are known before the start edge.

// File: rtl/plf_seq_pkg.sv
package plf_seq_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_FLUSH, ST_LOG, ST_OFF} seq_state_e;
  typedef enum logic [1:0] {CMT_NONE = 2'd0, CMT_HDR = 2'd1, CMT_CLOSE = 2'd2} commit_e;
  localparam int unsigned EVT_W = 8;
  localparam logic [EVT_W-1:0] EVT_HDR        = 8'hA1;
  localparam logic [EVT_W-1:0] EVT_DONE       = 8'hC0;
  localparam logic [EVT_W-1:0] EVT_INCOMPLETE = 8'hE5;
endpackage

// File: rtl/plf_detect_qual.sv
module plf_detect_qual #(
  parameter int unsigned QUAL_CYC  = 2,
  parameter int unsigned LAT_W     = 8,
  parameter int unsigned BIN_W     = 4,
  parameter int unsigned BIN_SHIFT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             pfail_i,
  output logic             detect_o,
  output logic [BIN_W-1:0] bin_o
);
  localparam int unsigned QW = $clog2(QUAL_CYC + 1);
  localparam logic [LAT_W-1:0] BIN_MAX = LAT_W'((1 << BIN_W) - 1);

  logic [QW-1:0]    q_cnt;
  logic             armed;
  logic [LAT_W-1:0] lat_cnt, lat_total, shifted;
  logic             qhit;

  assign qhit      = pfail_i && (q_cnt == QW'(QUAL_CYC - 1));
  assign detect_o  = en_i && qhit;
  // latency including the current edge, saturating
  assign lat_total = (lat_cnt == '1) ? lat_cnt : lat_cnt + 1'b1;
  assign shifted   = lat_total >> BIN_SHIFT;
  assign bin_o     = (shifted > BIN_MAX) ? BIN_MAX[BIN_W-1:0] : shifted[BIN_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_cnt   <= '0;
      armed   <= 1'b0;
      lat_cnt <= '0;
    end else if (en_i) begin
      if (!pfail_i)  q_cnt <= '0;
      else if (!qhit) q_cnt <= q_cnt + 1'b1;
      if (armed || pfail_i) lat_cnt <= lat_total;
      armed <= armed || pfail_i;
    end
  end
endmodule

// File: rtl/plf_hdr_pack.sv
module plf_hdr_pack
  import plf_seq_pkg::*;
#(
  parameter int unsigned LOG_W  = 16,
  parameter int unsigned TS_W   = 32,
  parameter int unsigned EP_W   = 16,
  parameter int unsigned SNAP_W = 16,
  parameter int unsigned BIN_W  = 4,
  localparam int unsigned RAW_W     = EVT_W + BIN_W + EP_W + TS_W + SNAP_W,
  localparam int unsigned HDR_WORDS = (RAW_W + LOG_W - 1) / LOG_W,
  localparam int unsigned IDX_W     = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [BIN_W-1:0]  bin_i,
  input  logic [TS_W-1:0]   ts_i,
  input  logic [EP_W-1:0]   ep_i,
  input  logic [SNAP_W-1:0] snap_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [LOG_W-1:0]  word_o
);
  localparam int unsigned HDR_W = HDR_WORDS * LOG_W;

  logic [HDR_W-1:0] hdr_q;
  logic [LOG_W-1:0] words [HDR_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hdr_q <= '0;
    else if (cap_i) hdr_q <= HDR_W'({EVT_HDR, bin_i, ep_i, ts_i, snap_i}) << (HDR_W - RAW_W);
  end

  for (genvar g = 0; g < HDR_WORDS; g++) begin : g_word
    assign words[g] = hdr_q[HDR_W-1-g*LOG_W -: LOG_W];
  end

  always_comb begin
    word_o = '0;
    for (int k = 0; k < HDR_WORDS; k++)
      if (idx_i == IDX_W'(k)) word_o = words[k];
  end
endmodule

// File: rtl/plf_flush_wdog.sv
module plf_flush_wdog #(
  parameter int unsigned FLUSH_TMO = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(FLUSH_TMO + 1);

  logic [CW-1:0] cnt;

  assign expire_o = run_i && (cnt == CW'(FLUSH_TMO - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt <= '0;
    else if (!run_i)    cnt <= '0;
    else if (!expire_o) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/plf_shutdown_seq.sv
module plf_shutdown_seq
  import plf_seq_pkg::*;
#(
  parameter int unsigned LOG_W     = 16,
  parameter int unsigned TS_W      = 32,
  parameter int unsigned EP_W      = 16,
  parameter int unsigned SNAP_W    = 16,
  parameter int unsigned BIN_W     = 4,
  parameter int unsigned BIN_SHIFT = 2,
  parameter int unsigned LAT_W     = 8,
  parameter int unsigned QUAL_CYC  = 2,
  parameter int unsigned FLUSH_TMO = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pfail_i,
  input  logic              vstore_ok_i,
  input  logic              flush_done_i,
  input  logic [TS_W-1:0]   tstamp_i,
  input  logic [EP_W-1:0]   epoch_i,
  input  logic [SNAP_W-1:0] snap_i,
  output logic              throttle_o,
  output logic              safe_entered_o,
  output logic              flush_req_o,
  output logic              log_we_o,
  output logic [LOG_W-1:0]  log_data_o,
  output logic              poweroff_o,
  output logic [BIN_W-1:0]  lat_bin_o,
  output logic [1:0]        last_commit_o
);
  localparam int unsigned RAW_W     = EVT_W + BIN_W + EP_W + TS_W + SNAP_W;
  localparam int unsigned HDR_WORDS = (RAW_W + LOG_W - 1) / LOG_W;
  localparam int unsigned IDX_W     = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1;

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  commit_e          commit_q, commit_d;
  logic [EVT_W-1:0] code_q, code_d;
  logic [BIN_W-1:0] bin_q, bin_now;
  logic             safe_q;
  logic             detect, expire;
  logic [LOG_W-1:0] hdr_word;

  plf_detect_qual #(
    .QUAL_CYC(QUAL_CYC), .LAT_W(LAT_W), .BIN_W(BIN_W), .BIN_SHIFT(BIN_SHIFT)
  ) u_qual (
    .clk_i, .rst_ni, .en_i(state_q == ST_IDLE), .pfail_i,
    .detect_o(detect), .bin_o(bin_now)
  );

  plf_hdr_pack #(
    .LOG_W(LOG_W), .TS_W(TS_W), .EP_W(EP_W), .SNAP_W(SNAP_W), .BIN_W(BIN_W)
  ) u_hdr (
    .clk_i, .rst_ni, .cap_i(detect), .bin_i(bin_now), .ts_i(tstamp_i),
    .ep_i(epoch_i), .snap_i, .idx_i(idx_q), .word_o(hdr_word)
  );

  plf_flush_wdog #(.FLUSH_TMO(FLUSH_TMO)) u_wdog (
    .clk_i, .rst_ni, .run_i(state_q == ST_FLUSH), .expire_o(expire)
  );

  // single entry from IDLE; no path back short of reset
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    commit_d = commit_q;
    code_d   = code_q;
    unique case (state_q)
      ST_IDLE: if (detect) begin
        state_d = ST_HDR;
        idx_d   = '0;
      end
      ST_HDR: begin
        if (!vstore_ok_i) state_d = ST_OFF;
        else if (idx_q == IDX_W'(HDR_WORDS - 1)) begin
          state_d  = ST_FLUSH;
          commit_d = CMT_HDR;
        end else idx_d = idx_q + 1'b1;
      end
      ST_FLUSH: begin
        if (!vstore_ok_i) state_d = ST_OFF;
        else if (flush_done_i) begin
          state_d = ST_LOG;
          code_d  = EVT_DONE;
        end else if (expire) begin
          state_d = ST_LOG;
          code_d  = EVT_INCOMPLETE;
        end
      end
      ST_LOG: begin
        state_d  = ST_OFF;
        commit_d = CMT_CLOSE;
      end
      ST_OFF:  state_d = ST_OFF;
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      commit_q <= CMT_NONE;
      code_q   <= '0;
      bin_q    <= '0;
      safe_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      commit_q <= commit_d;
      code_q   <= code_d;
      if (detect) begin
        bin_q  <= bin_now;
        safe_q <= 1'b1;
      end
    end
  end

  assign throttle_o     = (state_q != ST_IDLE);
  assign safe_entered_o = safe_q;
  assign flush_req_o    = (state_q == ST_FLUSH);
  assign poweroff_o     = (state_q == ST_OFF);
  assign log_we_o       = (state_q == ST_HDR) || (state_q == ST_LOG);
  assign log_data_o     = (state_q == ST_HDR) ? hdr_word
                                              : {code_q, tstamp_i[LOG_W-EVT_W-1:0]};
  assign lat_bin_o      = bin_q;
  assign last_commit_o  = commit_q;
endmodule

// File: rtl/plf_shutdown_seq_chk.sv
module plf_shutdown_seq_chk #(
  parameter int unsigned BIN_W     = 4,
  parameter int unsigned FLUSH_TMO = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             vstore_ok_i,
  input logic             throttle_o,
  input logic             safe_entered_o,
  input logic             flush_req_o,
  input logic             log_we_o,
  input logic             poweroff_o,
  input logic [BIN_W-1:0] lat_bin_o,
  input logic [1:0]       last_commit_o
);
  int unsigned fcnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          fcnt <= 0;
    else if (flush_req_o) fcnt <= fcnt + 1;
    else                  fcnt <= 0;
  end

  assert_throttle_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    throttle_o |=> throttle_o && safe_entered_o);

  assert_hdr_before_flush_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flush_req_o) |-> last_commit_o == 2'd1);

  assert_flush_needs_throttle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_req_o |-> throttle_o);

  assert_flush_bounded_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_req_o |-> fcnt < FLUSH_TMO);

  assert_forced_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (throttle_o && !vstore_ok_i) |=> poweroff_o);

  assert_off_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poweroff_o |=> poweroff_o && !log_we_o && !flush_req_o);

  assert_bin_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    throttle_o |=> $stable(lat_bin_o));
endmodule

bind plf_shutdown_seq plf_shutdown_seq_chk #(.BIN_W(BIN_W), .FLUSH_TMO(FLUSH_TMO)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .vstore_ok_i(vstore_ok_i), .throttle_o(throttle_o),
  .safe_entered_o(safe_entered_o), .flush_req_o(flush_req_o), .log_we_o(log_we_o),
  .poweroff_o(poweroff_o), .lat_bin_o(lat_bin_o), .last_commit_o(last_commit_o)
);

// File: tb/plf_shutdown_seq_tb_top.sv
module plf_shutdown_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pfail_i = 1'b0;
  logic        vstore_ok_i = 1'b1;
  logic        flush_done_i = 1'b0;
  logic [31:0] tstamp_i = '0;
  logic [15:0] epoch_i = '0;
  logic [15:0] snap_i = '0;
  logic        throttle_o, safe_entered_o, flush_req_o, log_we_o, poweroff_o;
  logic [15:0] log_data_o;
  logic [3:0]  lat_bin_o;
  logic [1:0]  last_commit_o;

  int n_checks = 0;
  int n_err = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  plf_shutdown_seq dut_i (.*);

  typedef struct packed {
    logic [7:0] gap;
    logic [7:0] done_dly;
    logic       chat;
  } vec_t;

  // gap: low cycles after a one-edge pulse (0 = no pulse); done_dly 255 = never
  localparam vec_t VECS [4] = '{
    '{8'd0,  8'd3,   1'b0},
    '{8'd3,  8'd16,  1'b1},
    '{8'd70, 8'd255, 1'b0},
    '{8'd9,  8'd17,  1'b1}
  };

  task automatic chk(input string req, input string what, input logic [79:0] act,
                     input logic [79:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_bin(input int lat);
    int b;
    b = lat >> 2;
    return (b > 15) ? 4'd15 : 4'(b);
  endfunction

  task automatic do_reset(input bit check_r1);
    rst_ni = 1'b0;
    pfail_i = 1'b0;
    vstore_ok_i = 1'b1;
    flush_done_i = 1'b0;
    repeat (3) @(negedge clk_i);
    if (check_r1) begin
      chk("R1", "reset outputs",
          80'({throttle_o, safe_entered_o, flush_req_o, log_we_o, poweroff_o}), 80'(0));
      chk("R1", "reset lat_bin", 80'(lat_bin_o), 80'(0));
      chk("R1", "reset last_commit", 80'(last_commit_o), 80'(0));
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic run_vec(input int i, input vec_t v);
    logic [31:0] ts, ts2;
    logic [79:0] hdr;
    logic [3:0]  bin;
    int          lat, cycles, dly, exp_cyc;
    logic [7:0]  code;
    do_reset(1'b0);
    ts = 32'h1000_0000 + 32'(i) * 32'h0101_0203;
    ts2 = ts ^ 32'h00FF_FF5A;
    tstamp_i = ts;
    epoch_i = 16'h0010 + 16'(i);
    snap_i = 16'hBEE0 + 16'(i);
    if (v.gap != 0) begin
      pfail_i = 1'b1;
      @(negedge clk_i);
      pfail_i = 1'b0;
      repeat (int'(v.gap)) @(negedge clk_i);
      lat = int'(v.gap) + 3;
    end else lat = 2;
    pfail_i = 1'b1;
    @(negedge clk_i);
    chk("R2", "no start after one high sample", 80'(throttle_o), 80'(0));
    @(negedge clk_i);
    chk("R2", "throttle and safe flag after qualification",
        80'({throttle_o, safe_entered_o}), 80'(2'b11));
    bin = exp_bin(lat);
    chk("R9", "latency bin", 80'(lat_bin_o), 80'(bin));
    hdr = {8'hA1, bin, epoch_i, ts, snap_i, 4'h0};
    for (int k = 0; k < 5; k++) begin
      chk("R3", "header strobe", 80'(log_we_o), 80'(1));
      chk("R3", "header word", 80'(log_data_o), 80'(hdr[79-16*k -: 16]));
      if (k == 0) tstamp_i = ts2;
      if (v.chat) pfail_i = ~pfail_i;
      @(negedge clk_i);
    end
    chk("R4", "flush after header", 80'({flush_req_o, log_we_o}), 80'(2'b10));
    chk("R4", "header committed", 80'(last_commit_o), 80'(1));
    dly = int'(v.done_dly);
    cycles = 1;
    while (flush_req_o && cycles < 40) begin
      if (cycles == dly) flush_done_i = 1'b1;
      if (v.chat) pfail_i = ~pfail_i;
      @(negedge clk_i);
      if (flush_req_o) cycles++;
    end
    flush_done_i = 1'b0;
    exp_cyc = (dly < 16) ? dly : 16;
    code = (dly <= 16) ? 8'hC0 : 8'hE5;
    chk((dly <= 16) ? "R5" : "R6", "flush cycles", 80'(cycles), 80'(exp_cyc));
    chk((dly <= 16) ? "R5" : "R6", "closing strobe", 80'(log_we_o), 80'(1));
    chk((dly <= 16) ? "R5" : "R6", "closing word", 80'(log_data_o), 80'({code, ts2[7:0]}));
    @(negedge clk_i);
    chk("R5", "power-off after closing",
        80'({poweroff_o, log_we_o, flush_req_o, throttle_o}), 80'(4'b1001));
    chk("R5", "closing committed", 80'(last_commit_o), 80'(2));
    if (v.chat) begin
      for (int k = 0; k < 6; k++) begin
        pfail_i = ~pfail_i;
        @(negedge clk_i);
        chk("R8", "pfail chatter after off",
            80'({poweroff_o, log_we_o, flush_req_o}), 80'(3'b100));
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1);

    // table-driven full sequences
    for (int i = 0; i < 4; i++) run_vec(i, VECS[i]);

    // R10: storage low before any power-fail is ignored
    do_reset(1'b0);
    vstore_ok_i = 1'b0;
    repeat (5) @(negedge clk_i);
    chk("R10", "idle ignores vstore low",
        80'({throttle_o, log_we_o, poweroff_o}), 80'(0));
    vstore_ok_i = 1'b1;

    // R7: forced off during header, then R8 chatter
    do_reset(1'b0);
    pfail_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R7", "in header before abort", 80'(log_we_o), 80'(1));
    vstore_ok_i = 1'b0;
    @(negedge clk_i);
    chk("R7", "forced off in header", 80'({poweroff_o, log_we_o, flush_req_o}), 80'(3'b100));
    chk("R7", "no commit after header abort", 80'(last_commit_o), 80'(0));
    vstore_ok_i = 1'b1;
    for (int k = 0; k < 6; k++) begin
      pfail_i = ~pfail_i;
      @(negedge clk_i);
      chk("R8", "no restart after off", 80'({poweroff_o, log_we_o, flush_req_o}), 80'(3'b100));
    end

    // R7: forced off during flush
    do_reset(1'b0);
    pfail_i = 1'b1;
    repeat (7) @(negedge clk_i);
    chk("R7", "in flush before abort", 80'(flush_req_o), 80'(1));
    vstore_ok_i = 1'b0;
    @(negedge clk_i);
    chk("R7", "forced off in flush", 80'({poweroff_o, log_we_o, flush_req_o}), 80'(3'b100));
    chk("R7", "header commit kept", 80'(last_commit_o), 80'(1));

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule